// File: doc/BRIEF.md
# Sampling Converter Host Bus Controller

This block is the digital side of a 10-bit bipolar sampling converter. It accepts active-low chip-select, read and write strobes from a host processor and synchronizes them to the conversion clock. A write with chip select starts a conversion, marked by an active-low hold strobe and a busy flag. At the end of the conversion the block captures the 10-bit code and the out-of-range flag. Both are offered through per-bit output enables that stand for three-state drivers. The quantizer itself is outside the block: a port supplies the code and the out-of-range bit, and the block samples them on the clock edge that ends a conversion.

The host can read the result as one 11-bit word. On an 8-bit bus it reads two bytes instead, selected by a byte-select pin. Holding write low makes conversions run back to back. Holding read low makes the outputs follow every new result.

Between the end of a low-byte read and the end of the matching high-byte read, the presented value is frozen. A conversion that finishes in that window cannot mix its bits into the pair being read.

Top module: `adc_host_if`

## Requirements
- R1: With `csN` low, a write pulse starts one conversion. With 2 synchronizer stages, `holdN` goes low after the third rising edge after `wrN` falls. From then on `busyOut` stays low for exactly CONV_CYCLES clocks (2 by default). `holdN` is low only during the first of those clocks.
- R2: A write pulse while `csN` is high starts nothing: `busyOut` and `holdN` stay high.
- R3: With `wrN` and `csN` held low, conversions repeat. `busyOut` rises once every CONV_CYCLES+1 clocks, which is 3 by default.
- R4: A write request that the synchronized logic sees only while a conversion is running is ignored. No second conversion follows it.
- R5: On the edge where `busyOut` rises, the presented value takes `cvtCode` on `dataOut[9:0]` and `cvtOvr` on `dataOut[10]`. Bit 9 is the sign bit of the two's-complement code. The presented value changes on no other edge, except the edge that ends a read.
- R6: When `busWide` is 1, all 11 bits of `dataOe` are 1 exactly while synchronized `rdN` and `csN` are both low. Otherwise they are all 0.
- R7: When `busWide` is 0 during a read, `byteHigh`=1 enables only `dataOe[10:8]` and `byteHigh`=0 enables only `dataOe[7:0]`.
- R8: With `rdN` and `csN` held low in wide mode, `dataOut` shows each new result from the edge where `busyOut` rises.
- R9: After a low-byte read (`busWide`=0, `byteHigh`=0) ends, the presented value stays frozen until a high-byte read or a wide read ends. It then shows the newest result.
- R10: `busyOe` is 0 when synchronized `rdN` and `csN` are both high, and 1 otherwise.
- R11: After reset, `busyOut`=1, `holdN`=1, `dataOut`=0, and both enables are 0 while the strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write (start) strobe, active low |
| busWide | input | 1 | 1: present the whole 11-bit word; 0: byte mode |
| byteHigh | input | 1 | Byte mode select: 1 high group (bits 10..8), 0 low byte |
| cvtCode | input | 10 | Code from the quantizer, sampled at end of conversion |
| cvtOvr | input | 1 | Out-of-range indication from the quantizer |
| holdN | output | 1 | Hold strobe, low in the first conversion clock |
| busyOut | output | 1 | Low while converting, high when complete |
| busyOe | output | 1 | Drive enable of the busy output |
| dataOut | output | 11 | Presented value: {overflow, code[9:0]} |
| dataOe | output | 11 | Per-bit drive enables of dataOut |

## Verification
Single write pulses carry random codes and overflow bits, and each result is read back as a wide word. This separates correct capture at the end of conversion from captures one edge early or late. A write pulse with chip select high and a second pulse that lands inside a running conversion show whether the start gating and the idle check are right. Holding write and read low while the code changes every clock exposes the repeat period and the transparent update. A low-byte read, then a conversion, then a high-byte read shows whether the byte pair stays coherent. Sweeping the read, chip-select and byte-select combinations separates the enable decoding of the word, the byte groups and the busy driver.

// File: rtl/adc_host_if_pkg.sv
`timescale 1ns/1ps
package adc_host_if_pkg;
  typedef enum logic {ST_IDLE, ST_CONV} convState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic eoc;       // end of conversion: capture quantizer output
    logic viewLoad;  // presented value may follow the result register
  } dpStrobe_t;
endpackage

// File: rtl/adc_host_if_sync.sv
`timescale 1ns/1ps
module adc_host_if_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/adc_host_if_ctrl.sv
`timescale 1ns/1ps
module adc_host_if_ctrl
  import adc_host_if_pkg::*;
#(
  parameter int CONV_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      rdS,
  input  logic      wrS,
  input  logic      busWide,
  input  logic      byteHigh,
  output logic      holdN,
  output logic      busy,
  output logic      rdEn,
  output dpStrobe_t strobe
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  convState_t state;
  logic [CW-1:0] cnt;
  logic startReq, lastCycle, rdEnD, readEnd, lock, lockNext;

  assign startReq  = !wrS && !csS;
  assign rdEn      = !rdS && !csS;
  assign lastCycle = (state == ST_CONV) && (cnt == CW'(CONV_CYCLES - 1));
  assign readEnd   = rdEnD && !rdEn;

  always_comb begin
    lockNext = lock;
    if (readEnd) lockNext = !busWide && !byteHigh;
  end

  assign strobe.eoc      = lastCycle;
  assign strobe.viewLoad = !lockNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      holdN <= 1'b1;
      busy  <= 1'b0;
      rdEnD <= 1'b0;
      lock  <= 1'b0;
    end else begin
      rdEnD <= rdEn;
      lock  <= lockNext;
      holdN <= 1'b1;
      unique case (state)
        ST_IDLE: if (startReq) begin
          state <= ST_CONV;
          cnt   <= '0;
          holdN <= 1'b0;
          busy  <= 1'b1;
        end
        ST_CONV: if (lastCycle) begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_host_if_dpath.sv
`timescale 1ns/1ps
module adc_host_if_dpath
  import adc_host_if_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CODE_W-1:0] cvtCode,
  input  logic              cvtOvr,
  input  logic              rdEn,
  input  logic              busWide,
  input  logic              byteHigh,
  output logic [CODE_W:0]   dataOut,
  output logic [CODE_W:0]   dataOe
);
  localparam int OW = CODE_W + 1;

  logic [OW-1:0] resultReg, viewReg, captured;

  assign captured = {cvtOvr, cvtCode};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      viewReg   <= '0;
    end else begin
      if (strobe.eoc) resultReg <= captured;
      if (strobe.viewLoad) viewReg <= strobe.eoc ? captured : resultReg;
    end
  end

  assign dataOut = viewReg;

  generate
    for (genvar i = 0; i < OW; i++) begin : g_oe
      localparam bit IS_HI = (i >= BYTE_W);
      assign dataOe[i] = rdEn && (busWide || (byteHigh == IS_HI));
    end
  endgenerate
endmodule

// File: rtl/adc_host_if.sv
`timescale 1ns/1ps
module adc_host_if
  import adc_host_if_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              busWide,
  input  logic              byteHigh,
  input  logic [CODE_W-1:0] cvtCode,
  input  logic              cvtOvr,
  output logic              holdN,
  output logic              busyOut,
  output logic              busyOe,
  output logic [CODE_W:0]   dataOut,
  output logic [CODE_W:0]   dataOe
);
  logic [2:0] strobeSync;
  logic csS, rdS, wrS, busy, rdEn;
  dpStrobe_t strobe;

  adc_host_if_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, rdN, wrN}), .syncOut(strobeSync)
  );
  assign {csS, rdS, wrS} = strobeSync;

  adc_host_if_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .rdS(rdS), .wrS(wrS),
    .busWide(busWide), .byteHigh(byteHigh),
    .holdN(holdN), .busy(busy), .rdEn(rdEn), .strobe(strobe)
  );

  adc_host_if_dpath #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cvtCode(cvtCode), .cvtOvr(cvtOvr),
    .rdEn(rdEn), .busWide(busWide), .byteHigh(byteHigh),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  assign busyOut = !busy;
  assign busyOe  = !(rdS && csS);
endmodule

// File: rtl/adc_host_if_chk.sv
`timescale 1ns/1ps
module adc_host_if_chk #(
  parameter int CODE_W      = 10,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            holdN,
  input logic            busyOut,
  input logic            busWide,
  input logic            rdEn,
  input logic [CODE_W:0] dataOut,
  input logic [CODE_W:0] dataOe
);
  logic [15:0] lowCnt;
  logic rdEnD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      rdEnD  <= 1'b0;
    end else begin
      lowCnt <= busyOut ? 16'd0 : lowCnt + 16'd1;
      rdEnD  <= rdEn;
    end
  end

  // R1: busy never stays low longer than a conversion
  a_r1_busy_max: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> lowCnt < 16'(CONV_CYCLES));
  // R1: busy returns high only after a full conversion
  a_r1_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> lowCnt == 16'(CONV_CYCLES));
  // R1: hold low only in the first busy clock
  a_r1_hold_first: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> (!busyOut && lowCnt == 16'd0));
  // R4: a new conversion begins only from the idle state
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdN) |-> $past(busyOut));
  // R5: presented value moves only at end of conversion or end of a read
  a_r5_data_moves: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> ($rose(busyOut) || ($past(rdEnD) && !$past(rdEn))));
  // R6: no drive without a read
  a_r6_oe_gated: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> dataOe == '0);
  // R7: byte mode never drives both groups
  a_r7_byte_groups: assert property (@(posedge clk) disable iff (!rstN)
    !busWide |-> !((|dataOe[CODE_W:BYTE_W]) && (|dataOe[BYTE_W-1:0])));
endmodule

bind adc_host_if adc_host_if_chk #(
  .CODE_W(CODE_W), .BYTE_W(BYTE_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .holdN(holdN), .busyOut(busyOut),
  .busWide(busWide), .rdEn(rdEn), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/adc_host_if_bench.sv
`timescale 1ns/1ps
module adc_host_if_bench;
  localparam int CONV = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, busWide = 1'b1, byteHigh = 1'b0;
  logic [9:0] cvtCode = '0;
  logic cvtOvr = 1'b0;
  logic holdN, busyOut, busyOe;
  logic [10:0] dataOut, dataOe;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_host_if u_adc_host_if (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busWide(busWide), .byteHigh(byteHigh), .cvtCode(cvtCode), .cvtOvr(cvtOvr),
    .holdN(holdN), .busyOut(busyOut), .busyOe(busyOe),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [10:0] packWord(logic ovr, logic [9:0] code);
    return {ovr, code};
  endfunction

  function automatic logic [10:0] oeFor(logic wide, logic hi);
    if (wide) return 11'h7FF;
    return hi ? 11'h700 : 11'h0FF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitDone();
    int t = 0;
    while (busyOut && t < 20) begin cyc(1); t++; end
    while (!busyOut && t < 40) begin cyc(1); t++; end
  endtask

  task automatic runConv(logic [9:0] code, logic ovr);
    cvtCode = code; cvtOvr = ovr;
    csN = 1'b0; wrN = 1'b0;
    cyc(1);
    wrN = 1'b1;
    waitDone();
  endtask

  task automatic readWide(string req, logic [10:0] exp);
    busWide = 1'b1; rdN = 1'b0;
    cyc(2);
    chk(req, dataOut, exp);
    chk("R6 wide enables", dataOe, 11'h7FF);
    rdN = 1'b1;
    cyc(3);
  endtask

  initial begin
    logic [10:0] wordA, wordB, prevDriven, want;
    int rises, lastRise, busyFalls;
    logic prevBusy;
    void'($urandom(32'd4711));

    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R11 reset state
    chk("R11 busy", busyOut, 1'b1);
    chk("R11 hold", holdN, 1'b1);
    chk("R11 data", dataOut, 11'h000);
    chk("R11 data oe", dataOe, 11'h000);
    chk("R10 busy oe idle", busyOe, 1'b0);

    // R1 start latency and busy length
    cvtCode = 10'h2A5; cvtOvr = 1'b0;
    csN = 1'b0; wrN = 1'b0;
    cyc(1); wrN = 1'b1;
    cyc(1);
    chk("R1 hold not yet", holdN, 1'b1);
    cyc(1);
    chk("R1 hold low", holdN, 1'b0);
    chk("R1 busy low", busyOut, 1'b0);
    cyc(1);
    chk("R1 hold released", holdN, 1'b1);
    chk("R1 busy still low", busyOut, 1'b0);
    cyc(1);
    chk("R1 busy done", busyOut, 1'b1);
    readWide("R5 first result", packWord(1'b0, 10'h2A5));

    // R2 write ignored without chip select
    csN = 1'b1; cvtCode = 10'h111;
    cyc(1); wrN = 1'b0; cyc(1); wrN = 1'b1;
    begin
      logic quiet = 1'b1;
      for (int i = 0; i < 8; i++) begin
        cyc(1);
        if (!busyOut || !holdN) quiet = 1'b0;
      end
      chk("R2 no conversion", quiet, 1'b1);
    end
    csN = 1'b0;
    readWide("R2 result unchanged", packWord(1'b0, 10'h2A5));

    // R4 request during busy ignored
    cvtCode = 10'h0F0; cvtOvr = 1'b1;
    busyFalls = 0; prevBusy = busyOut;
    wrN = 1'b0; cyc(1); wrN = 1'b1; cyc(1); wrN = 1'b0; cyc(1); wrN = 1'b1;
    if (!busyOut) busyFalls++;
    prevBusy = busyOut;
    for (int i = 0; i < 14; i++) begin
      cyc(1);
      if (prevBusy && !busyOut) busyFalls++;
      prevBusy = busyOut;
    end
    chk("R4 single conversion", busyFalls, 1);
    readWide("R5 overflow bit", packWord(1'b1, 10'h0F0));

    // R3 / R8 continuous conversion with transparent read
    busWide = 1'b1; rdN = 1'b0; wrN = 1'b0;
    prevDriven = packWord(1'b0, 10'h000);
    rises = 0; lastRise = -1; prevBusy = busyOut;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      if (!prevBusy && busyOut) begin
        chk("R8 transparent update", dataOut, prevDriven);
        if (lastRise >= 0) chk("R3 repeat period", i - lastRise, CONV + 1);
        lastRise = i;
        rises++;
      end
      prevBusy = busyOut;
      cvtCode = 10'($urandom); cvtOvr = 1'($urandom);
      prevDriven = packWord(cvtOvr, cvtCode);
    end
    chk("R3 enough conversions", rises >= 6, 1'b1);
    wrN = 1'b1; rdN = 1'b1;
    cyc(8);

    // R10 / R6 / R7 enable decoding
    csN = 1'b1; rdN = 1'b1; cyc(3);
    chk("R10 busy oe off", busyOe, 1'b0);
    csN = 1'b0; cyc(3);
    chk("R10 busy oe on cs", busyOe, 1'b1);
    chk("R6 no read no drive", dataOe, 11'h000);
    csN = 1'b1; rdN = 1'b0; cyc(3);
    chk("R10 busy oe on rd", busyOe, 1'b1);
    chk("R6 read without cs", dataOe, 11'h000);
    rdN = 1'b1; csN = 1'b0; cyc(3);

    // R9 byte coherence across a conversion
    wordA = packWord(1'b1, 10'h1FF);
    wordB = packWord(1'b0, 10'h203);
    runConv(wordA[9:0], wordA[10]);
    busWide = 1'b0; byteHigh = 1'b0; rdN = 1'b0; cyc(2);
    chk("R7 low byte oe", dataOe, oeFor(1'b0, 1'b0));
    chk("R9 low byte A", dataOut[7:0], wordA[7:0]);
    rdN = 1'b1; cyc(3);
    runConv(wordB[9:0], wordB[10]);
    cyc(2);
    byteHigh = 1'b1; rdN = 1'b0; cyc(2);
    chk("R7 high byte oe", dataOe, oeFor(1'b0, 1'b1));
    chk("R9 high byte still A", dataOut[10:8], wordA[10:8]);
    rdN = 1'b1; cyc(3);
    readWide("R9 newest after pair", wordB);

    // random single conversions
    for (int i = 0; i < 16; i++) begin
      logic [9:0] c;
      logic o;
      c = 10'($urandom); o = 1'($urandom);
      runConv(c, o);
      want = packWord(o, c);
      if (i % 2 == 0) begin
        readWide("R5 random result", want);
      end else begin
        busWide = 1'b0; byteHigh = 1'b0; rdN = 1'b0; cyc(2);
        chk("R7 random low byte", dataOut[7:0], want[7:0]);
        rdN = 1'b1; cyc(3);
        byteHigh = 1'b1; rdN = 1'b0; cyc(2);
        chk("R7 random high byte", dataOut[10:8], want[10:8]);
        rdN = 1'b1; cyc(3);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule